// File: doc/BRIEF.md
# Segment Table Address Translator

This block turns a logical address, given as a segment number and an offset, into a physical address. It uses a small segment table held in registers. Each entry of the table describes one segment: where it starts in physical memory (its base), how long it is (its limit), and which kinds of access it allows (read, write, instruction fetch). A separate count register sets how many segments are in use.

A request passes three checks in a fixed order. First, the segment number must be below the count. Second, the offset must be below the entry's limit. Third, the access type must be allowed by the entry. If all three pass, the result is the base plus the offset. If any check fails, the result is a fault with a cause code, and the physical address is zero. Results are registered and leave through a valid/ready handshake. Requests enter through a matching handshake.

The table and the count register are loaded through a plain write port with address, data and write-enable. A write lands on the clock edge, so any request accepted in a later cycle sees the new contents.

Top module: `seg_xlat`

## Requirements
- R1: After reset no result is valid, `req_ready` is 1, the count register is 0 and every table entry is 0, so the first request faults with cause 1.
- R2: A segment number equal to or above the count register gives `res_fault`=1 with `res_cause`=1.
- R3: An offset equal to or above the selected entry's limit gives a fault with `res_cause`=2. An offset of limit-1 is legal.
- R4: Access types are encoded as 0=read, 1=write, 2=fetch and 3=reserved. They need permission bit 0 (read), bit 1 (write) or bit 2 (execute) of the entry. A missing permission, or type 3, gives a fault with `res_cause`=3.
- R5: A legal access returns `res_pa` = base + offset, taken modulo 2^PA_W.
- R6: Two segment numbers whose entries hold the same base map the same offset to the same physical address.
- R7: When several checks fail at once, the cause reported is the first failing check in the order segment number (1), then limit (2), then permission (3).
- R8: A faulting result has `res_pa`=0. `res_cause` is nonzero exactly when `res_fault`=1, and 0 on a legal result.
- R9: A request accepted on a clock edge (`req_valid` and `req_ready` both 1) is presented on `res_valid` after that edge. The result holds steady while `res_ready`=0. `req_ready` equals `!res_valid || res_ready`.
- R10: A write with `cfg_addr[SEG_W]`=1 loads `cfg_data[SEG_W:0]` into the count register. Otherwise the write loads entry `cfg_addr[SEG_W-1:0]` with the layout {perm[2:0], limit[OFF_W-1:0], base[PA_W-1:0]}, most significant field first. The write affects requests accepted in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | SEG_W+1 | Entry index; the top bit selects the count register |
| cfg_data | input | 3+OFF_W+PA_W | Entry contents or count value |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_seg | input | SEG_W | Segment number |
| req_off | input | OFF_W | Offset within the segment |
| req_acc | input | 2 | Access type |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Result consumer can take it |
| res_fault | output | 1 | Translation faulted |
| res_cause | output | 2 | Fault cause, 0 when legal |
| res_pa | output | PA_W | Physical address, 0 on fault |

## Verification
The assertions assume two things about the environment. First, reset is held for at least one edge before traffic starts. Second, `req_valid` and `res_ready` always carry known values. They do not assume that a request stays stable while `req_ready` is low. The bench drives every input only on the falling edge and keeps it constant through the following rising edge. It never raises `req_valid` before reset is released. It only drops `res_ready` while it deliberately holds a result back to exercise the stall path.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    typedef enum logic [1:0] {
        CAUSE_NONE   = 2'd0,
        CAUSE_SEGNUM = 2'd1,
        CAUSE_LIMIT  = 2'd2,
        CAUSE_PERM   = 2'd3
    } cause_e;

    localparam int PERM_R   = 0;
    localparam int PERM_W   = 1;
    localparam int PERM_X   = 2;
    localparam int PERM_NUM = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20,
    localparam int ENT_W = PERM_NUM + OFF_W + PA_W,
    localparam int NSEG  = 1 << SEG_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [SEG_W:0]      cfg_addr,
    input  logic [ENT_W-1:0]    cfg_data,
    input  logic [SEG_W-1:0]    rd_seg,
    output logic [PA_W-1:0]     rd_base,
    output logic [OFF_W-1:0]    rd_limit,
    output logic [PERM_NUM-1:0] rd_perm,
    output logic [SEG_W:0]      seg_count
);

    logic [ENT_W-1:0] ent_arr [NSEG];
    logic [SEG_W:0]   cnt_d, cnt_q;
    logic             ent_sel;

    assign ent_sel = cfg_we && !cfg_addr[SEG_W];

    for (genvar i = 0; i < NSEG; i++) begin : g_ent
        logic [ENT_W-1:0] ent_d, ent_q;

        always_comb begin
            ent_d = ent_q;
            if (ent_sel && (cfg_addr[SEG_W-1:0] == SEG_W'(i))) begin
                ent_d = cfg_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) ent_q <= '0;
            else        ent_q <= ent_d;
        end

        assign ent_arr[i] = ent_q;
    end

    always_comb begin
        cnt_d = cnt_q;
        if (cfg_we && cfg_addr[SEG_W]) begin
            cnt_d = cfg_data[SEG_W:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    logic [ENT_W-1:0] rd_ent;
    assign rd_ent    = ent_arr[rd_seg];
    assign rd_base   = rd_ent[PA_W-1:0];
    assign rd_limit  = rd_ent[PA_W +: OFF_W];
    assign rd_perm   = rd_ent[PA_W+OFF_W +: PERM_NUM];
    assign seg_count = cnt_q;

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input  logic [SEG_W-1:0]    seg,
    input  logic [OFF_W-1:0]    off,
    input  logic [1:0]          acc,
    input  logic [SEG_W:0]      seg_count,
    input  logic [PA_W-1:0]     base,
    input  logic [OFF_W-1:0]    limit,
    input  logic [PERM_NUM-1:0] perm,
    output logic                fault,
    output cause_e              cause,
    output logic [PA_W-1:0]     pa
);

    logic seg_bad, lim_bad, perm_ok;

    always_comb begin
        seg_bad = ({1'b0, seg} >= seg_count);
        lim_bad = (off >= limit);
        unique case (acc_e'(acc))
            ACC_READ:  perm_ok = perm[PERM_R];
            ACC_WRITE: perm_ok = perm[PERM_W];
            ACC_FETCH: perm_ok = perm[PERM_X];
            default:   perm_ok = 1'b0;
        endcase

        if (seg_bad)       cause = CAUSE_SEGNUM;
        else if (lim_bad)  cause = CAUSE_LIMIT;
        else if (!perm_ok) cause = CAUSE_PERM;
        else               cause = CAUSE_NONE;

        fault = (cause != CAUSE_NONE);
        pa    = fault ? '0 : (base + PA_W'(off));
    end

endmodule

// File: rtl/seg_xlat.sv
module seg_xlat
    import seg_xlat_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20,
    localparam int ENT_W = PERM_NUM + OFF_W + PA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SEG_W:0]    cfg_addr,
    input  logic [ENT_W-1:0]  cfg_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic [OFF_W-1:0]  req_off,
    input  logic [1:0]        req_acc,
    output logic              res_valid,
    input  logic              res_ready,
    output logic              res_fault,
    output logic [1:0]        res_cause,
    output logic [PA_W-1:0]   res_pa
);

    typedef struct packed {
        logic            vld;
        logic            fault;
        cause_e          cause;
        logic [PA_W-1:0] pa;
    } res_t;

    logic [PA_W-1:0]     tb_base;
    logic [OFF_W-1:0]    tb_limit;
    logic [PERM_NUM-1:0] tb_perm;
    logic [SEG_W:0]      tb_count;
    logic                ck_fault;
    cause_e              ck_cause;
    logic [PA_W-1:0]     ck_pa;

    seg_table #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_data  (cfg_data),
        .rd_seg    (req_seg),
        .rd_base   (tb_base),
        .rd_limit  (tb_limit),
        .rd_perm   (tb_perm),
        .seg_count (tb_count)
    );

    seg_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_check (
        .seg       (req_seg),
        .off       (req_off),
        .acc       (req_acc),
        .seg_count (tb_count),
        .base      (tb_base),
        .limit     (tb_limit),
        .perm      (tb_perm),
        .fault     (ck_fault),
        .cause     (ck_cause),
        .pa        (ck_pa)
    );

    res_t res_d, res_q;
    logic take;

    assign req_ready = !res_q.vld || res_ready;
    assign take      = req_valid && req_ready;

    always_comb begin
        res_d = res_q;
        if (take) begin
            res_d.vld   = 1'b1;
            res_d.fault = ck_fault;
            res_d.cause = ck_cause;
            res_d.pa    = ck_pa;
        end else if (res_ready) begin
            res_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) res_q <= '{vld: 1'b0, fault: 1'b0, cause: CAUSE_NONE, pa: '0};
        else        res_q <= res_d;
    end

    assign res_valid = res_q.vld;
    assign res_fault = res_q.fault;
    assign res_cause = res_q.cause;
    assign res_pa    = res_q.pa;

endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
    parameter int PA_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            req_ready,
    input logic            res_valid,
    input logic            res_ready,
    input logic            res_fault,
    input logic [1:0]      res_cause,
    input logic [PA_W-1:0] res_pa
);

    a_r8_fault_pa_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_fault) |-> (res_pa == '0));

    a_r8_cause_flag: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_fault == (res_cause != 2'd0)));

    a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_pa)
                                       && $stable(res_cause) && $stable(res_fault)));

    a_r9_no_take_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |-> !req_ready);

    a_r9_take_gives_result: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> res_valid);

endmodule

bind seg_xlat seg_xlat_chk #(.PA_W(PA_W)) i_seg_xlat_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .res_valid (res_valid),
    .res_ready (res_ready),
    .res_fault (res_fault),
    .res_cause (res_cause),
    .res_pa    (res_pa)
);

// File: tb/test_seg_xlat.sv
module test_seg_xlat;

    localparam int SEG_W = 3;
    localparam int OFF_W = 16;
    localparam int PA_W  = 20;
    localparam int ENT_W = 3 + OFF_W + PA_W;
    localparam int NSEG  = 1 << SEG_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [SEG_W:0]   cfg_addr = '0;
    logic [ENT_W-1:0] cfg_data = '0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [SEG_W-1:0] req_seg = '0;
    logic [OFF_W-1:0] req_off = '0;
    logic [1:0]       req_acc = '0;
    logic             res_valid;
    logic             res_ready = 1'b1;
    logic             res_fault;
    logic [1:0]       res_cause;
    logic [PA_W-1:0]  res_pa;

    always #10 clk = ~clk;

    seg_xlat #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) i_seg_xlat (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .req_valid(req_valid), .req_ready(req_ready),
        .req_seg(req_seg), .req_off(req_off), .req_acc(req_acc),
        .res_valid(res_valid), .res_ready(res_ready), .res_fault(res_fault),
        .res_cause(res_cause), .res_pa(res_pa)
    );

    typedef struct {
        logic            fault;
        logic [1:0]      cause;
        logic [PA_W-1:0] pa;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [PA_W-1:0]  m_base [NSEG];
    logic [OFF_W-1:0] m_lim  [NSEG];
    logic [2:0]       m_perm [NSEG];
    int               m_cnt;

    function automatic exp_t model(int seg, int off, int acc, string tag);
        exp_t e;
        bit ok_p;
        e.tag = tag;
        ok_p = (acc == 0) ? m_perm[seg][0] : (acc == 1) ? m_perm[seg][1] :
               (acc == 2) ? m_perm[seg][2] : 1'b0;
        if (seg >= m_cnt)              e.cause = 2'd1;
        else if (off >= int'(m_lim[seg])) e.cause = 2'd2;
        else if (!ok_p)                e.cause = 2'd3;
        else                           e.cause = 2'd0;
        e.fault = (e.cause != 2'd0);
        e.pa    = e.fault ? '0 : PA_W'(int'(m_base[seg]) + off);
        return e;
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    task automatic cfg_entry(int idx, int base, int lim, int perm);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = (SEG_W+1)'(idx);
        cfg_data = {3'(perm), OFF_W'(lim), PA_W'(base)};
        m_base[idx] = PA_W'(base);
        m_lim[idx]  = OFF_W'(lim);
        m_perm[idx] = 3'(perm);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_count(int cnt);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_addr = {1'b1, SEG_W'(0)};
        cfg_data = ENT_W'(cnt);
        m_cnt = cnt;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(int seg, int off, int acc, string tag);
        @(negedge clk);
        req_valid = 1'b1;
        req_seg = SEG_W'(seg);
        req_off = OFF_W'(off);
        req_acc = 2'(acc);
        #1;
        while (!req_ready) begin
            @(negedge clk);
            #1;
        end
        exp_q.push_back(model(seg, off, acc, tag));
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (rst_n && res_valid && res_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R9", "unexpected result", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(res_fault == e.fault, e.tag, "fault", res_fault, e.fault);
                    check(res_cause == e.cause, e.tag, "cause", res_cause, e.cause);
                    check(res_pa == e.pa, e.tag, "pa", res_pa, e.pa);
                end
            end
        end
    end

    // watchdog
    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NSEG; i++) begin
            m_base[i] = '0; m_lim[i] = '0; m_perm[i] = '0;
        end
        m_cnt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #5;
        check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);

        // R1: count is zero after reset
        send(0, 0, 0, "R1");

        // table setup: perm bit0=r, bit1=w, bit2=x (R10 layout)
        cfg_entry(0, 'h01400, 1000, 3'b001);
        cfg_entry(1, 'h06300, 400,  3'b101);
        cfg_entry(2, 'h04300, 1100, 3'b011);
        cfg_entry(3, 'h01400, 1000, 3'b100);
        cfg_entry(4, 'hFFFF0, 'h100, 3'b111);
        cfg_count(5);

        send(0, 53, 0, "R5");
        send(2, 777, 1, "R5");
        send(4, 'h20, 0, "R5_wrap");
        send(0, 999, 0, "R3_edge_ok");
        send(0, 1000, 0, "R3");
        send(2, 4000, 1, "R3");
        send(5, 0, 0, "R2");
        send(7, 10, 2, "R2");
        send(0, 12, 1, "R4_write_ro");
        send(3, 12, 0, "R4_read_xo");
        send(3, 12, 2, "R6");
        send(0, 12, 0, "R6");
        send(1, 5, 2, "R4_fetch_ok");
        send(2, 5, 2, "R4_fetch_bad");
        send(4, 5, 3, "R4_reserved");
        send(6, 5000, 1, "R7_seg_first");
        send(0, 5000, 1, "R7_limit_first");
        send(3, 1000, 0, "R7_limit_over_perm");

        // R9: stall holds result and blocks requests
        @(negedge clk);
        res_ready = 1'b0;
        send(1, 100, 0, "R9");
        repeat (3) @(negedge clk);
        #5;
        check(res_valid == 1'b1, "R9", "res_valid in stall", res_valid, 1);
        check(req_ready == 1'b0, "R9", "req_ready in stall", req_ready, 0);
        check(res_pa == PA_W'('h06300 + 100), "R9", "pa in stall", res_pa, 'h06300 + 100);
        @(negedge clk);
        res_ready = 1'b1;

        // R10: rewrite count and an entry; later requests see new contents
        cfg_count(2);
        send(3, 12, 2, "R10_count");
        cfg_entry(0, 'h00200, 50, 3'b010);
        send(0, 40, 1, "R10_entry");
        send(0, 50, 1, "R10_entry");

        res_ready = 1'b1;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule